// File: doc/BRIEF.md
# Single-PWM Adaptive Dead-Time Gate Controller

This block turns one PWM command into two gate commands for a half bridge: `ho_o` for the high-side switch and `lo_o` for the low-side switch. It runs on one clock, and every delay is a parameter counted in clock cycles. The gap between the two gates is not a fixed count. Each handoff waits for a digitized sense flag that says the switch being turned off is really off.

There are two sense flags. `lo_gate_off_i` reports that the low-side gate voltage is below its off level. `sw_node_low_i` reports that the switch node has dropped.

Once the low side is on, it is held on until PWM rises again. This keeps switch-node ringing from chopping the low-side pulse. Two timers run from the PWM falling edge:
- a minimum-delay timer sets the earliest moment the low side may turn on after a very fast switch-node fall;
- a timeout timer turns the low side on anyway if the switch node is never seen low.

An enable input and two undervoltage flags force both gates off. The block restarts from its off state when they clear. PWM and both sense flags pass through two-flop synchronizers. Enable and the undervoltage flags are taken as synchronous.

Top module: `hb_deadtime_ctrl`

Latency convention: an input change is first sampled at clock edge k. `SYN` = 2 is the synchronizer depth, which applies to PWM and the sense flags.

## Requirements
- R1: `ho_o` and `lo_o` are low out of reset. While `enable_i` is low or either undervoltage flag is high, both outputs are low, starting from the first edge that samples the condition.
- R2: `ho_o` and `lo_o` are never high in the same cycle.
- R3: A rising PWM sampled at edge k drives `lo_o` low at edge k+SYN+`LO_OFF_DLY`.
- R4: After `lo_o` has fallen, `ho_o` stays low for as long as `lo_gate_off_i` is low. Once that flag is sampled high at edge k, `ho_o` rises at edge k+SYN+`HO_ON_DLY`.
- R5: A falling PWM sampled at edge k drives `ho_o` low at edge k+SYN+`HO_OFF_DLY`.
- R6: After `ho_o` falls, `lo_o` stays low while `sw_node_low_i` is low. Let m be the edge that samples the flag high and k the edge that sampled PWM low. `lo_o` rises at the later of edge m+SYN+`LO_ON_DLY` and edge k+SYN+`FAST_MIN_DLY`.
- R7: If `sw_node_low_i` is never sampled high, `lo_o` rises at edge k+SYN+`SW_TIMEOUT`, where k samples PWM low.
- R8: Once `lo_o` is high with PWM low, it stays high whatever `sw_node_low_i` does, until PWM is sampled high.
- R9: When the block becomes enabled at edge k, it starts as follows:
  - with PWM low, it behaves as if PWM fell at edge k−SYN, so `lo_o` rises no earlier than edge k+`FAST_MIN_DLY`;
  - with PWM high, it waits for `lo_gate_off_i`, and `ho_o` rises `HO_ON_DLY` edges after the first FSM step that sees the flag high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable, active high |
| uvlo_vdd_i | input | 1 | Low-side supply undervoltage flag |
| uvlo_boot_i | input | 1 | Bootstrap supply undervoltage flag |
| pwm_i | input | 1 | PWM command, high selects the high side |
| lo_gate_off_i | input | 1 | Low-side gate is below its off level |
| sw_node_low_i | input | 1 | Switch node has dropped below its threshold |
| ho_o | output | 1 | High-side gate command |
| lo_o | output | 1 | Low-side gate command |

## Verification
The falling-PWM handoff is driven in three ways, and each makes a different term decide the low-side turn-on:
- a switch-node flag that arrives late, so `LO_ON_DLY` counted from the flag decides;
- a flag already high when the high side drops, so the fast-fall minimum from the PWM edge decides;
- a flag that never arrives, so the timeout decides.

The rising handoff holds the low-side-off flag low for many cycles, which shows that the high side waits on the sense flag and not on a fixed delay.

Further cases cover:
- toggling the switch-node flag with the low side latched on;
- an undervoltage fault during conduction;
- restarts from the disabled state with PWM high and with PWM low.

Each edge is sampled one cycle before and at the cycle it is due, so an off-by-one shows up.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    typedef enum logic [3:0] {
        ST_OFF,        // both gates off, block disabled
        ST_LO_ON,      // low side conducting, latched
        ST_LO_FALL,    // PWM rose, low side still on during turn-off delay
        ST_WAIT_GATE,  // low side commanded off, waiting for gate-off flag
        ST_HO_DLY,     // gate-off seen, counting before high side turns on
        ST_HO_ON,      // high side conducting
        ST_HO_FALL,    // PWM fell, high side still on during turn-off delay
        ST_WAIT_SW,    // high side off, waiting for switch node to drop
        ST_LO_DLY      // switch node seen low, counting before low side turns on
    } hb_state_e;

endpackage

// File: rtl/hb_sync2.sv
module hb_sync2 #(
    parameter int WIDTH = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [1:0] stage_d, stage_q;

        always_comb begin
            stage_d = {stage_q[0], din_i[b]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q <= '0;
            else         stage_q <= stage_d;
        end

        assign dout_o[b] = stage_q[1];
    end

endmodule

// File: rtl/hb_sat_timer.sv
module hb_sat_timer #(
    parameter int W   = 4,
    parameter int MAX = 9
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] CAP = W'(MAX);

    logic [W-1:0] count_d, count_q;

    always_comb begin
        if (clr_i)             count_d = '0;
        else if (count_q < CAP) count_d = count_q + 1'b1;
        else                   count_d = count_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) count_q <= '0;
        else         count_q <= count_d;
    end

    assign count_o = count_q;

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
    import hb_dt_pkg::*;
#(
    parameter int LO_OFF_DLY   = 9,
    parameter int HO_ON_DLY    = 9,
    parameter int HO_OFF_DLY   = 9,
    parameter int LO_ON_DLY    = 9,
    parameter int FAST_MIN_DLY = 20,
    parameter int SW_TIMEOUT   = 63
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic uvlo_vdd_i,
    input  logic uvlo_boot_i,
    input  logic pwm_i,
    input  logic lo_gate_off_i,
    input  logic sw_node_low_i,
    output logic ho_o,
    output logic lo_o
);

    localparam int MAX_A    = (LO_OFF_DLY > HO_ON_DLY)  ? LO_OFF_DLY : HO_ON_DLY;
    localparam int MAX_B    = (HO_OFF_DLY > LO_ON_DLY)  ? HO_OFF_DLY : LO_ON_DLY;
    localparam int MAX_STEP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int STEP_W   = $clog2(MAX_STEP + 1);
    localparam int FALL_W   = $clog2(SW_TIMEOUT + 1);

    localparam logic [STEP_W-1:0] LO_OFF_M1 = STEP_W'(LO_OFF_DLY - 1);
    localparam logic [STEP_W-1:0] HO_ON_M1  = STEP_W'(HO_ON_DLY - 1);
    localparam logic [STEP_W-1:0] HO_OFF_M1 = STEP_W'(HO_OFF_DLY - 1);
    localparam logic [STEP_W-1:0] LO_ON_M1  = STEP_W'(LO_ON_DLY - 1);
    localparam logic [FALL_W-1:0] FAST_M1   = FALL_W'(FAST_MIN_DLY - 1);
    localparam logic [FALL_W-1:0] TMO_M1    = FALL_W'(SW_TIMEOUT - 1);

    typedef struct packed {
        hb_state_e state;
        logic      ho;
        logic      lo;
    } ctrl_t;

    logic [2:0]        sync_q;
    logic              pwm_s, gate_off_s, sw_low_s;
    logic              run;
    logic              step_clr, fall_clr;
    logic [STEP_W-1:0] step_cnt;
    logic [FALL_W-1:0] fall_cnt;
    ctrl_t             ctrl_d, ctrl_q;

    hb_sync2 #(.WIDTH(3)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({sw_node_low_i, lo_gate_off_i, pwm_i}),
        .dout_o (sync_q)
    );

    assign pwm_s      = sync_q[0];
    assign gate_off_s = sync_q[1];
    assign sw_low_s   = sync_q[2];
    assign run        = enable_i && !uvlo_vdd_i && !uvlo_boot_i;

    // Cycles spent in the current state
    hb_sat_timer #(.W(STEP_W), .MAX(MAX_STEP)) i_step_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (step_clr),
        .count_o (step_cnt)
    );

    // Cycles since the PWM falling edge reached the state machine
    hb_sat_timer #(.W(FALL_W), .MAX(SW_TIMEOUT)) i_fall_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (fall_clr),
        .count_o (fall_cnt)
    );

    always_comb begin
        ctrl_d   = ctrl_q;
        fall_clr = 1'b0;
        if (!run) begin
            ctrl_d.state = ST_OFF;
        end else begin
            unique case (ctrl_q.state)
                ST_OFF: begin
                    if (pwm_s) begin
                        ctrl_d.state = ST_WAIT_GATE;
                    end else begin
                        ctrl_d.state = ST_WAIT_SW;
                        fall_clr     = 1'b1;
                    end
                end
                ST_LO_ON: begin
                    if (pwm_s) ctrl_d.state = ST_LO_FALL;
                end
                ST_LO_FALL: begin
                    if (!pwm_s)                      ctrl_d.state = ST_LO_ON;
                    else if (step_cnt >= LO_OFF_M1)  ctrl_d.state = ST_WAIT_GATE;
                end
                ST_WAIT_GATE: begin
                    if (!pwm_s) begin
                        ctrl_d.state = ST_WAIT_SW;
                        fall_clr     = 1'b1;
                    end else if (gate_off_s) begin
                        ctrl_d.state = ST_HO_DLY;
                    end
                end
                ST_HO_DLY: begin
                    if (!pwm_s) begin
                        ctrl_d.state = ST_WAIT_SW;
                        fall_clr     = 1'b1;
                    end else if (step_cnt >= HO_ON_M1) begin
                        ctrl_d.state = ST_HO_ON;
                    end
                end
                ST_HO_ON: begin
                    if (!pwm_s) begin
                        ctrl_d.state = ST_HO_FALL;
                        fall_clr     = 1'b1;
                    end
                end
                ST_HO_FALL: begin
                    if (pwm_s)                       ctrl_d.state = ST_HO_ON;
                    else if (step_cnt >= HO_OFF_M1)  ctrl_d.state = ST_WAIT_SW;
                end
                ST_WAIT_SW: begin
                    if (pwm_s)                  ctrl_d.state = ST_WAIT_GATE;
                    else if (fall_cnt >= TMO_M1) ctrl_d.state = ST_LO_ON;
                    else if (sw_low_s)          ctrl_d.state = ST_LO_DLY;
                end
                ST_LO_DLY: begin
                    if (pwm_s)
                        ctrl_d.state = ST_WAIT_GATE;
                    else if ((step_cnt >= LO_ON_M1 && fall_cnt >= FAST_M1) ||
                             fall_cnt >= TMO_M1)
                        ctrl_d.state = ST_LO_ON;
                end
                default: ctrl_d.state = ST_OFF;
            endcase
        end
        step_clr  = (ctrl_d.state != ctrl_q.state);
        ctrl_d.ho = (ctrl_d.state inside {ST_HO_ON, ST_HO_FALL});
        ctrl_d.lo = (ctrl_d.state inside {ST_LO_ON, ST_LO_FALL});
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctrl_q <= '{state: ST_OFF, ho: 1'b0, lo: 1'b0};
        else         ctrl_q <= ctrl_d;
    end

    assign ho_o = ctrl_q.ho;
    assign lo_o = ctrl_q.lo;

endmodule

// File: rtl/hb_deadtime_chk.sv
module hb_deadtime_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic enable_i,
    input logic uvlo_vdd_i,
    input logic uvlo_boot_i,
    input logic pwm_s,
    input logic ho_o,
    input logic lo_o
);

    logic run_c;
    assign run_c = enable_i && !uvlo_vdd_i && !uvlo_boot_i;

    // R2
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ho_o && lo_o));

    // R1
    fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_c |=> (!ho_o && !lo_o));

    // R8
    lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_o && !pwm_s && run_c) |=> lo_o);

    // R4
    ho_after_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ho_o) |-> !$past(lo_o));

    // R6
    lo_after_ho_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lo_o) |-> !$past(ho_o));

endmodule

bind hb_deadtime_ctrl hb_deadtime_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .uvlo_vdd_i  (uvlo_vdd_i),
    .uvlo_boot_i (uvlo_boot_i),
    .pwm_s       (pwm_s),
    .ho_o        (ho_o),
    .lo_o        (lo_o)
);

// File: tb/test_hb_deadtime_ctrl.sv
module test_hb_deadtime_ctrl;

    localparam int LOF = 9, HON = 9, HOF = 9, LON = 9, FMIN = 20, TMO = 63;
    localparam int SYN = 2;

    logic clk = 1'b0, rst_ni = 1'b0;
    logic en, uvv, uvb, pwm, gof, swl;
    logic ho, lo;
    int   cyc = 0, checks = 0, fails = 0, overlap_n = 0;
    bit   done = 1'b0;

    typedef struct {
        int    at;
        bit    ch;
        logic  h;
        bit    cl;
        logic  l;
        string req;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hb_deadtime_ctrl #(
        .LO_OFF_DLY(LOF), .HO_ON_DLY(HON), .HO_OFF_DLY(HOF),
        .LO_ON_DLY(LON), .FAST_MIN_DLY(FMIN), .SW_TIMEOUT(TMO)
    ) i_hb_deadtime_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .enable_i(en), .uvlo_vdd_i(uvv),
        .uvlo_boot_i(uvb), .pwm_i(pwm), .lo_gate_off_i(gof),
        .sw_node_low_i(swl), .ho_o(ho), .lo_o(lo)
    );

    task automatic push(int at, bit ch, logic h, bit cl, logic l, string req);
        exp_t e;
        e.at = at; e.ch = ch; e.h = h; e.cl = cl; e.l = l; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops expectations in order and compares at their cycle
    always @(negedge clk) begin
        if (rst_ni && ho && lo) begin
            overlap_n++;
            $display("FAIL R2 cyc=%0d actual ho=1 lo=1 expected not both high", cyc);
        end
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.at != cyc) begin
                fails++;
                $display("FAIL %s sample missed actual cyc=%0d expected cyc=%0d", e.req, cyc, e.at);
            end else if ((e.ch && ho !== e.h) || (e.cl && lo !== e.l)) begin
                fails++;
                $display("FAIL %s cyc=%0d actual ho=%b lo=%b expected ho=%b lo=%b (ho chk %0d, lo chk %0d)",
                         e.req, cyc, ho, lo, e.h, e.l, e.ch, e.cl);
            end
        end
    end

    initial begin
        int k, m;
        en = 0; uvv = 0; uvb = 0; pwm = 0; gof = 1; swl = 1;
        idle(4);
        rst_ni = 1'b1;
        push(cyc + 1, 1, 0, 1, 0, "R1");
        push(cyc + 3, 1, 0, 1, 0, "R1");
        idle(5);

        // Startup with PWM low and node already low: fast minimum governs (R9, R6)
        en = 1; k = cyc + 1;
        push(k + FMIN - 1, 0, 0, 1, 0, "R6");
        push(k + FMIN,     1, 0, 1, 1, "R9");
        idle(FMIN + 5);

        // Rising PWM: LO off after delay, HO waits for gate-off flag (R3, R4)
        pwm = 1; gof = 0; k = cyc + 1;
        push(k + SYN + LOF - 1, 0, 0, 1, 1, "R3");
        push(k + SYN + LOF,     1, 0, 1, 0, "R3");
        push(k + 25,            1, 0, 1, 0, "R4");
        idle(30);
        gof = 1; k = cyc + 1;
        push(k + SYN + HON - 1, 1, 0, 1, 0, "R4");
        push(k + SYN + HON,     1, 1, 1, 0, "R4");
        idle(HON + 6);

        // Falling PWM with slow switch node: LO_ON_DLY from flag governs (R5, R6)
        pwm = 0; swl = 0; k = cyc + 1;
        push(k + SYN + HOF - 1, 1, 1, 0, 0, "R5");
        push(k + SYN + HOF,     1, 0, 1, 0, "R5");
        push(k + 25,            1, 0, 1, 0, "R6");
        idle(30);
        swl = 1; m = cyc + 1;
        push(m + SYN + LON - 1, 0, 0, 1, 0, "R6");
        push(m + SYN + LON,     1, 0, 1, 1, "R6");
        idle(15);

        // Switch-node flag drops while LO latched: LO holds (R8)
        swl = 0; k = cyc + 1;
        push(k + 10, 1, 0, 1, 1, "R8");
        idle(12);
        swl = 1;
        idle(3);

        // Switch node never seen low: timeout forces LO (R7)
        pwm = 1; gof = 0; k = cyc + 1;
        push(k + SYN + LOF, 1, 0, 1, 0, "R3");
        idle(14);
        gof = 1; k = cyc + 1;
        push(k + SYN + HON, 1, 1, 1, 0, "R4");
        idle(HON + 5);
        pwm = 0; swl = 0; k = cyc + 1;
        push(k + SYN + TMO - 1, 1, 0, 1, 0, "R7");
        push(k + SYN + TMO,     1, 0, 1, 1, "R7");
        idle(TMO + 5);
        swl = 1;

        // Node already low when HO drops: fast minimum governs (R6)
        pwm = 1; gof = 0;
        idle(14);
        gof = 1;
        idle(HON + 5);
        pwm = 0; k = cyc + 1;
        push(k + SYN + HOF,      1, 0, 1, 0, "R5");
        push(k + SYN + FMIN - 1, 1, 0, 1, 0, "R6");
        push(k + SYN + FMIN,     1, 0, 1, 1, "R6");
        idle(FMIN + 6);

        // Undervoltage during conduction, restart with PWM high, then disable (R1, R9)
        uvb = 1; k = cyc + 1;
        push(k,     1, 0, 1, 0, "R1");
        push(k + 4, 1, 0, 1, 0, "R1");
        idle(6);
        pwm = 1; gof = 1;
        idle(5);
        uvb = 0; k = cyc + 1;
        push(k + HON,     1, 0, 1, 0, "R9");
        push(k + HON + 1, 1, 1, 1, 0, "R9");
        idle(HON + 4);
        en = 0; k = cyc + 1;
        push(k,     1, 0, 1, 0, "R1");
        push(k + 3, 1, 0, 1, 0, "R1");
        idle(6);

        while (q.size() > 0) idle(1);
        checks++;
        if (overlap_n != 0) begin
            fails++;
            $display("FAIL R2 overlap cycles actual=%0d expected=0", overlap_n);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-all actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule